// File: doc/BRIEF.md
# Power-Down Wake Controller

This block sequences an embedded controller core into and out of two low-power states. A halt request from the running core parks it in a light sleep: instructions stop, but the oscillator keeps running. A stop request parks it in a deep sleep, where the oscillator enable is also dropped. Both states share the same two wake sources. The first is the reset input. The second is a host write into the core's input data buffer.

The resume action depends on the wake source. A host write resumes the core either through a call to the input-buffer interrupt routine, when that interrupt is enabled, or at the next instruction. Reset restarts the core from program address zero. When the oscillator has been off, the block counts a stabilization interval of `STAB_CYCLES` clock cycles after raising the oscillator enable, and only then lets the core run. The controller then marks the resume with a one-cycle `vector_irq` pulse (interrupt call) or a one-cycle `restart` pulse (reset restart). A resume at the next instruction gives no pulse.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: While running, a sampled `halt_req` drops `core_run` on the next cycle and keeps `osc_en` high.
- R2: While running, a sampled `stop_req` drops both `core_run` and `osc_en` on the next cycle. When `halt_req` and `stop_req` are both high, the stop request wins.
- R3: In light sleep, a sampled `host_write` raises `core_run` on the following cycle. `vector_irq` pulses with it if `ibf_int_en` was high in the write cycle. Otherwise neither `vector_irq` nor `restart` pulses.
- R4: In deep sleep, a sampled `host_write` raises `osc_en` on the next cycle. `core_run` rises exactly `STAB_CYCLES` cycles after `osc_en` rises. `vector_irq` pulses then only if `ibf_int_en` was high in the write cycle.
- R5: While `rst` is high, `core_run` is low and `osc_en` is high. After a reset that began in light sleep or while running, `core_run` rises on the first clock edge that samples `rst` low, together with a `restart` pulse.
- R6: After a reset that began in deep sleep, `core_run` rises no sooner than `STAB_CYCLES` cycles after `osc_en` rises and not while `rst` is high. If `rst` is released early, the rise comes exactly `STAB_CYCLES` cycles after `osc_en` rises.
- R7: When `rst` and `host_write` are both high in the same cycle, reset wins: the resume gives a `restart` pulse and no `vector_irq`.
- R8: `vector_irq` and `restart` each last one cycle. They occur only on the first cycle of a new `core_run` high period and are never high together.
- R9: `halt_req` and `stop_req` have no effect while asleep or stabilizing. `host_write` has no effect while running or stabilizing.
- R10: During reset, `vector_irq` and `restart` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Active-high reset; also a wake source |
| halt_req | input | 1 | Request for light sleep (oscillator stays on) |
| stop_req | input | 1 | Request for deep sleep (oscillator gated) |
| host_write | input | 1 | One-cycle strobe: host wrote the input data buffer |
| ibf_int_en | input | 1 | Input-buffer-full interrupt enable |
| core_run | output | 1 | High while the core may execute instructions |
| osc_en | output | 1 | Oscillator driver enable |
| vector_irq | output | 1 | One-cycle pulse: resume by calling the input-buffer interrupt routine |
| restart | output | 1 | One-cycle pulse: resume from program address zero |

## Verification
Each sleep state is left by a host write, once with the interrupt enabled and once with it disabled. This separates the vector and next-instruction resumes, and the latency (zero or `STAB_CYCLES`) separates light sleep from deep sleep. Reset is applied from the running state, from light sleep together with a host write, and from deep sleep both as a single-cycle pulse and held past the stabilization window. These patterns show reset priority, that the restart waits for the oscillator, and that the restart also waits for reset release. Sleep requests sent while asleep and host writes sent while running or stabilizing must leave both the expected resume times and the enables unchanged.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

   typedef enum logic [2:0] {
      PD_RSTH = 3'd0,   // reset held / waiting for release
      PD_RUN  = 3'd1,
      PD_SOFT = 3'd2,   // light sleep, oscillator on
      PD_HARD = 3'd3,   // deep sleep, oscillator gated
      PD_WARM = 3'd4    // oscillator warming up after host wake
   } pd_state_e;

   typedef enum logic [1:0] {
      RES_NONE    = 2'd0,
      RES_IRQ     = 2'd1,
      RES_RESTART = 2'd2
   } resume_e;

endpackage

// File: rtl/pwrdn_stab_timer.sv
module pwrdn_stab_timer #(
   parameter int STAB_CYCLES = 1024
) (
   input  logic clk,
   input  logic load_i,
   input  logic count_i,
   output logic done_o
);

   localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;

   generate
      if (STAB_CYCLES == 1) begin : g_no_wait
         logic unused_ctl;
         assign unused_ctl = ^{clk, load_i, count_i};
         assign done_o = 1'b1;
      end else begin : g_counter
         localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STAB_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (load_i)
               cnt_q <= LOAD_VAL;
            else if (!count_i)
               cnt_q <= '0;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end

         assign done_o = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
   import pwrdn_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      halt_req,
   input  logic      stop_req,
   input  logic      host_write,
   input  logic      ibf_int_en,
   input  logic      stab_done,
   output pd_state_e state_o,
   output logic      timer_load,
   output logic      timer_count,
   output logic      fire_o,
   output resume_e   kind_o
);

   pd_state_e state_q, state_n;
   logic      want_irq_q, want_irq_n;

   always_comb begin
      state_n    = state_q;
      want_irq_n = want_irq_q;
      kind_o     = RES_NONE;
      if (rst) begin
         state_n = PD_RSTH;
      end else begin
         unique case (state_q)
            PD_RSTH: if (stab_done) begin
               state_n = PD_RUN;
               kind_o  = RES_RESTART;
            end
            PD_RUN: begin
               if (stop_req)      state_n = PD_HARD;
               else if (halt_req) state_n = PD_SOFT;
            end
            PD_SOFT: if (host_write) begin
               state_n = PD_RUN;
               kind_o  = ibf_int_en ? RES_IRQ : RES_NONE;
            end
            PD_HARD: if (host_write) begin
               state_n    = PD_WARM;
               want_irq_n = ibf_int_en;
            end
            PD_WARM: if (stab_done) begin
               state_n = PD_RUN;
               kind_o  = want_irq_q ? RES_IRQ : RES_NONE;
            end
            default: state_n = PD_RSTH;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      state_q    <= state_n;
      want_irq_q <= want_irq_n;
   end

   assign timer_load  = (state_q == PD_HARD) && (rst || host_write);
   assign timer_count = (state_q == PD_RSTH) || (state_q == PD_WARM);
   assign fire_o      = (state_n == PD_RUN) && (state_q != PD_RUN);
   assign state_o     = state_q;

endmodule

// File: rtl/pwrdn_resume_gen.sv
module pwrdn_resume_gen
   import pwrdn_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    fire_i,
   input  resume_e kind_i,
   output logic    vector_irq_o,
   output logic    restart_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         vector_irq_o <= 1'b0;
         restart_o    <= 1'b0;
      end else begin
         vector_irq_o <= fire_i && (kind_i == RES_IRQ);
         restart_o    <= fire_i && (kind_i == RES_RESTART);
      end
   end

endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl
   import pwrdn_pkg::*;
#(
   parameter int STAB_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst,
   input  logic halt_req,
   input  logic stop_req,
   input  logic host_write,
   input  logic ibf_int_en,
   output logic core_run,
   output logic osc_en,
   output logic vector_irq,
   output logic restart
);

   generate
      if (STAB_CYCLES < 1) begin : g_bad_stab
         $error("pwrdn_wake_ctrl: STAB_CYCLES must be at least 1");
      end
   endgenerate

   pd_state_e fsm_state;
   logic      stab_done, t_load, t_count, fire;
   resume_e   kind;

   pwrdn_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
      .clk     (clk),
      .load_i  (t_load),
      .count_i (t_count),
      .done_o  (stab_done)
   );

   pwrdn_fsm u_fsm (
      .clk         (clk),
      .rst         (rst),
      .halt_req    (halt_req),
      .stop_req    (stop_req),
      .host_write  (host_write),
      .ibf_int_en  (ibf_int_en),
      .stab_done   (stab_done),
      .state_o     (fsm_state),
      .timer_load  (t_load),
      .timer_count (t_count),
      .fire_o      (fire),
      .kind_o      (kind)
   );

   pwrdn_resume_gen u_resume (
      .clk          (clk),
      .rst          (rst),
      .fire_i       (fire),
      .kind_i       (kind),
      .vector_irq_o (vector_irq),
      .restart_o    (restart)
   );

   assign core_run = (fsm_state == PD_RUN);
   assign osc_en   = (fsm_state != PD_HARD);

endmodule

// File: rtl/pwrdn_wake_chk.sv
module pwrdn_wake_chk
   import pwrdn_pkg::*;
#(
   parameter int STAB_CYCLES = 1024
) (
   input logic      clk,
   input logic      rst,
   input logic      halt_req,
   input logic      stop_req,
   input logic      host_write,
   input logic      ibf_int_en,
   input logic      core_run,
   input logic      osc_en,
   input logic      vector_irq,
   input logic      restart,
   input pd_state_e fsm_state
);

   int   on_cnt   = 0;
   logic from_off = 1'b0;

   always_ff @(posedge clk) begin
      if (!osc_en) begin
         on_cnt   <= 0;
         from_off <= 1'b1;
      end else begin
         if (!core_run && on_cnt < STAB_CYCLES) on_cnt <= on_cnt + 1;
         if (core_run) from_off <= 1'b0;
      end
   end

   AST_HALT_KEEPS_OSC: assert property (@(posedge clk) disable iff (rst)
      (core_run && halt_req && !stop_req) |=> (!core_run && osc_en)); // R1

   AST_STOP_GATES_OSC: assert property (@(posedge clk) disable iff (rst)
      (core_run && stop_req) |=> (!core_run && !osc_en)); // R2

   AST_SOFT_WAKE: assert property (@(posedge clk) disable iff (rst)
      (fsm_state == PD_SOFT && host_write) |=>
         (core_run && vector_irq == $past(ibf_int_en) && !restart)); // R3

   AST_STAB_WAIT: assert property (@(posedge clk) disable iff (rst)
      ($rose(core_run) && from_off) |-> (on_cnt >= STAB_CYCLES)); // R4

   AST_PULSE_ONE_IRQ: assert property (@(posedge clk) disable iff (rst)
      vector_irq |=> !vector_irq); // R8

   AST_PULSE_ONE_RST: assert property (@(posedge clk) disable iff (rst)
      restart |=> !restart); // R8

   AST_PULSE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
      (vector_irq || restart) |-> (core_run && !$past(core_run))); // R8

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(vector_irq && restart)); // R8

   AST_DEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!osc_en && !host_write) |=> !osc_en); // R9

   AST_ASLEEP_NO_STOP: assert property (@(posedge clk) disable iff (rst)
      (osc_en && !core_run && stop_req) |=> osc_en); // R9

endmodule

bind pwrdn_wake_ctrl pwrdn_wake_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .halt_req   (halt_req),
   .stop_req   (stop_req),
   .host_write (host_write),
   .ibf_int_en (ibf_int_en),
   .core_run   (core_run),
   .osc_en     (osc_en),
   .vector_irq (vector_irq),
   .restart    (restart),
   .fsm_state  (fsm_state)
);

// File: tb/tb_pwrdn_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pwrdn_wake_ctrl;

   localparam int STAB = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic halt_req = 1'b0, stop_req = 1'b0, host_write = 1'b0, ibf_int_en = 1'b0;
   logic core_run, osc_en, vector_irq, restart;

   always #10 clk = ~clk;   // 50 MHz

   pwrdn_wake_ctrl #(.STAB_CYCLES(STAB)) dut (
      .clk(clk), .rst(rst), .halt_req(halt_req), .stop_req(stop_req),
      .host_write(host_write), .ibf_int_en(ibf_int_en),
      .core_run(core_run), .osc_en(osc_en),
      .vector_irq(vector_irq), .restart(restart)
   );

   typedef struct {
      int    at;
      logic  irq;
      logic  rs;
      string req;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_chk = 0, n_fail = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input int at, input logic irq, input logic rs, input string req);
      exp_t e;
      e.at = at; e.irq = irq; e.rs = rs; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: pop an expected resume on every rise of core_run
   logic prev_run = 1'b0, prev_v = 1'b0, prev_r = 1'b0;
   always @(negedge clk) begin
      if (!done) begin
         if (core_run && !prev_run) begin
            if (sb.size() == 0) begin
               chk(0, "R9 unexpected resume", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(cyc == e.at, {e.req, " resume cycle"}, cyc, e.at);
               chk(vector_irq == e.irq, {e.req, " vector_irq"}, int'(vector_irq), int'(e.irq));
               chk(restart == e.rs, {e.req, " restart"}, int'(restart), int'(e.rs));
            end
         end else if (!rst && (vector_irq || restart)) begin
            chk(0, "R8 pulse outside resume", int'({vector_irq, restart}), 0);
         end
         if ((prev_v && vector_irq) || (prev_r && restart))
            chk(0, "R8 pulse longer than one cycle", 2, 1);
         prev_run = core_run;
         prev_v   = vector_irq;
         prev_r   = restart;
      end
   end

   task automatic do_halt();
      halt_req = 1'b1; tick(1); halt_req = 1'b0;
   endtask

   task automatic do_stop();
      stop_req = 1'b1; tick(1); stop_req = 1'b0;
   endtask

   task automatic wake(input logic en, input int delay, input string req);
      host_write = 1'b1; ibf_int_en = en;
      push(cyc + 1 + delay, en, 1'b0, req);
      tick(1);
      host_write = 1'b0; ibf_int_en = 1'b0;
   endtask

   initial begin
      // R10: reset state, held past the stabilization window
      tick(2);
      chk(core_run == 1'b0, "R10 core_run in reset", int'(core_run), 0);
      chk(osc_en == 1'b1, "R5 osc_en in reset", int'(osc_en), 1);
      chk(!vector_irq && !restart, "R10 pulses in reset", int'({vector_irq, restart}), 0);
      tick(STAB + 2);
      rst = 1'b0;
      push(cyc + 1, 1'b0, 1'b1, "R5");
      tick(3);

      // R1 light sleep; R9 stop ignored while asleep; R3 wake with interrupt
      do_halt();
      chk(core_run == 1'b0, "R1 core_run after halt", int'(core_run), 0);
      chk(osc_en == 1'b1, "R1 osc_en after halt", int'(osc_en), 1);
      do_stop();
      chk(osc_en == 1'b1, "R9 stop ignored in light sleep", int'(osc_en), 1);
      wake(1'b1, 0, "R3");
      tick(2);

      // R3 wake to next instruction
      do_halt();
      wake(1'b0, 0, "R3");
      tick(2);

      // R2 deep sleep; R9 halt ignored; R4 wake with interrupt after warm-up
      do_stop();
      chk(osc_en == 1'b0, "R2 osc_en after stop", int'(osc_en), 0);
      chk(core_run == 1'b0, "R2 core_run after stop", int'(core_run), 0);
      do_halt();
      chk(osc_en == 1'b0, "R9 halt ignored in deep sleep", int'(osc_en), 0);
      wake(1'b1, STAB, "R4");
      chk(osc_en == 1'b1, "R4 osc_en after host wake", int'(osc_en), 1);
      tick(3);
      host_write = 1'b1; tick(1); host_write = 1'b0;   // R9 ignored while warming
      tick(STAB);

      // R2 stop wins over halt; R4 wake without interrupt
      halt_req = 1'b1; stop_req = 1'b1; tick(1); halt_req = 1'b0; stop_req = 1'b0;
      chk(osc_en == 1'b0, "R2 stop priority", int'(osc_en), 0);
      wake(1'b0, STAB, "R4");
      tick(STAB + 3);

      // R9 host write while running
      host_write = 1'b1; ibf_int_en = 1'b1; tick(1); host_write = 1'b0; ibf_int_en = 1'b0;
      tick(2);
      chk(core_run == 1'b1, "R9 host write while running", int'(core_run), 1);

      // R7 reset and host write together from light sleep
      do_halt();
      rst = 1'b1; host_write = 1'b1; ibf_int_en = 1'b1;
      push(cyc + 2, 1'b0, 1'b1, "R7");
      tick(1);
      rst = 1'b0; host_write = 1'b0; ibf_int_en = 1'b0;
      tick(3);

      // R6 short reset from deep sleep: waits the full window
      do_stop();
      rst = 1'b1;
      push(cyc + 1 + STAB, 1'b0, 1'b1, "R6");
      tick(1);
      rst = 1'b0;
      tick(STAB + 3);

      // R6 long reset from deep sleep: waits for release
      do_stop();
      rst = 1'b1;
      tick(STAB + 5);
      chk(core_run == 1'b0, "R6 no run while reset held", int'(core_run), 0);
      rst = 1'b0;
      push(cyc + 1, 1'b0, 1'b1, "R6");
      tick(3);

      // R5 reset from running
      rst = 1'b1;
      push(cyc + 2, 1'b0, 1'b1, "R5");
      tick(1);
      rst = 1'b0;
      tick(4);

      chk(sb.size() == 0, "R8 all expected resumes seen", sb.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         chk(0, "R1 watchdog expired", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule